// File: doc/BRIEF.md
# Snooping Invalidation Coherence Cluster

This block is a small bus-based multiprocessor memory system. It holds several private direct-mapped caches, one per processor port, a shared memory, and one arbitrated snooping bus. Each cache line follows a four-state invalidation protocol with these states: invalid, clean-exclusive, clean-shared and dirty. A read miss fills clean-exclusive when no other cache holds the line, so a later write to that line needs no bus traffic. When another cache does hold the line, that cache supplies the data directly and memory is not used.

Each processor port raises a request with an address, a write flag and write data, and keeps it raised until its done pulse. Hits complete locally in one cycle. Misses, and writes to shared lines, request the bus. A transaction occupies the bus for two cycles. In the first cycle, the address cycle, every other cache snoops the address and updates its own copy. In the second cycle, the response cycle, the registered shared status selects the data source: another cache or memory. The requester fills its line at the end of the response cycle. A probe port reports the state of any line in any cache.

Top module: `snoop_coh_cluster`

## Requirements
- R1: After reset every line of every cache probes as invalid (state code 0), `bus_valid` is 0 and no done is raised.
- R2: A read miss that no other cache holds produces one bus read (op code 1). `bus_shared` and `bus_c2c` are 0 in the response cycle. The data comes from memory and the line becomes clean-exclusive (state code 1).
- R3: A read miss that another cache holds produces one bus read. `bus_shared` and `bus_c2c` are 1 in the cycle after the address cycle. The data is the holder's copy and the line becomes clean-shared (state code 2).
- R4: A read hit in any valid state, or a write hit in clean-exclusive or dirty, completes with no bus transaction. A write hit leaves the line dirty (state code 3).
- R5: A write hit in clean-shared issues one invalidate (op code 3). The writer ends dirty and every other copy becomes invalid.
- R6: A write to a line not held issues one write-miss (op code 2). The writer ends dirty with the written data and every other copy becomes invalid.
- R7: A snooped bus read demotes a dirty or clean-exclusive copy to clean-shared. A snooped write-miss or invalidate makes any copy invalid. Copies of other addresses are untouched.
- R8: A dirty cache that supplies a snooped read writes its data to memory in the same transaction. A dirty line displaced by a fill is written to memory.
- R9: Only one transaction is on the bus at a time. Every address cycle is followed by exactly one response cycle, and requests raised together are served one after the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | NCPU | Per-processor request, held until done |
| cpu_we | input | NCPU | Per-processor write flag |
| cpu_addr | input | NCPU*AW | Per-processor word address, packed |
| cpu_wdata | input | NCPU*DW | Per-processor write data, packed |
| cpu_done | output | NCPU | One-cycle completion pulse |
| cpu_rdata | output | NCPU*DW | Read data (write data for writes), valid with done |
| bus_valid | output | 1 | Address cycle of a bus transaction |
| bus_op | output | 2 | Transaction code: 0 none, 1 read, 2 write-miss, 3 invalidate |
| bus_src | output | SW | Index of the requesting cache |
| bus_addr | output | AW | Transaction address |
| bus_shared | output | 1 | Response cycle: some other cache held the line |
| bus_c2c | output | 1 | Response cycle: read data supplied by a cache |
| probe_cpu | input | SW | Cache selected for probing |
| probe_addr | input | AW | Address probed |
| probe_state | output | 2 | Line state: 0 invalid, 1 clean-exclusive, 2 clean-shared, 3 dirty |

## Verification
The bench builds the block with three caches of four lines, 4-bit addresses and 8-bit data. Sixteen words of memory against four lines per cache make index conflicts easy to set up. Displacing clean and dirty lines can then be checked by re-reading an address from memory. Three caches let the bench reach a state where one cache is dirty while a second cache reads and a third is checked. They also allow two simultaneous write-misses to the same line to be raised while a third cache observes the winner's data.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_INV   = 2'd0,
    ST_EXCL  = 2'd1,
    ST_SHRD  = 2'd2,
    ST_DIRTY = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BOP_NONE  = 2'd0,
    BOP_READ  = 2'd1,
    BOP_WMISS = 2'd2,
    BOP_INVAL = 2'd3
  } bus_op_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_RESP = 2'd2
  } bus_ph_t;

  // Power-on memory pattern: word a holds a*17+3
  function automatic logic [31:0] mem_seed(input int a);
    return 32'(a * 17 + 3);
  endfunction

  // State of a snooping copy after the bus operation
  function automatic line_st_t snoop_next(input line_st_t cur, input bus_op_t op);
    case (op)
      BOP_READ:            return (cur == ST_EXCL || cur == ST_DIRTY) ? ST_SHRD : cur;
      BOP_WMISS, BOP_INVAL: return ST_INV;
      default:             return cur;
    endcase
  endfunction

  // Bus operation a processor access needs, given lookup result
  function automatic bus_op_t need_op(input logic hit, input logic we, input line_st_t cur);
    if (!hit)                      return we ? BOP_WMISS : BOP_READ;
    else if (we && cur == ST_SHRD) return BOP_INVAL;
    else                           return BOP_NONE;
  endfunction

  // State the requester installs at the end of its transaction
  function automatic line_st_t fill_state(input bus_op_t op, input logic shared);
    if (op == BOP_READ) return shared ? ST_SHRD : ST_EXCL;
    else                return ST_DIRTY;
  endfunction

endpackage

// File: rtl/coh_mem.sv
module coh_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data
);
  import coh_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(mem_seed(i));
    end else begin
      if (wa_en) mem[wa_addr] <= wa_data;
      if (wb_en) mem[wb_addr] <= wb_data;
    end
  end
endmodule

// File: rtl/coh_bus_arb.sv
module coh_bus_arb #(
  parameter int NCPU = 3,
  parameter int AW   = 4,
  parameter int SW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCPU-1:0]    req,
  input  logic [2*NCPU-1:0]  op_flat,
  input  logic [AW*NCPU-1:0] addr_flat,
  output logic               bus_valid,
  output logic               bus_resp,
  output logic               bus_busy,
  output logic [SW-1:0]      own_idx,
  output coh_pkg::bus_op_t   bus_op,
  output logic [AW-1:0]      bus_addr
);
  import coh_pkg::*;

  bus_ph_t       phase;
  logic [SW-1:0] ptr;
  logic          found;
  logic [SW-1:0] pick;

  // Round-robin search starting at ptr
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCPU; k++) begin
      int j;
      j = (int'(ptr) + k) % NCPU;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = SW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ptr      <= '0;
      own_idx  <= '0;
      bus_op   <= BOP_NONE;
      bus_addr <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (found) begin
          own_idx  <= pick;
          bus_op   <= bus_op_t'(op_flat[int'(pick)*2 +: 2]);
          bus_addr <= addr_flat[int'(pick)*AW +: AW];
          phase    <= PH_ADDR;
        end
        PH_ADDR: phase <= PH_RESP;
        default: begin
          phase <= PH_IDLE;
          ptr   <= SW'((int'(own_idx) + 1) % NCPU);
        end
      endcase
    end
  end

  assign bus_valid = (phase == PH_ADDR);
  assign bus_resp  = (phase == PH_RESP);
  assign bus_busy  = bus_valid | bus_resp;
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int NLINE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             bus_req,
  output coh_pkg::bus_op_t want_op,
  input  logic             mine,
  input  logic             bus_valid,
  input  logic             bus_resp,
  input  coh_pkg::bus_op_t bus_op,
  input  logic [AW-1:0]    bus_addr,
  input  logic             shared_in,
  input  logic [DW-1:0]    resp_data,
  output logic             snp_hit,
  output logic             snp_dirty,
  output logic [DW-1:0]    snp_data,
  output logic             vic_we,
  output logic [AW-1:0]    vic_addr,
  output logic [DW-1:0]    vic_data,
  input  logic [AW-1:0]    probe_addr,
  output logic [1:0]       probe_st
);
  import coh_pkg::*;
  localparam int IW = $clog2(NLINE);
  localparam int TW = AW - IW;

  line_st_t      st  [NLINE];
  logic [TW-1:0] tg  [NLINE];
  logic [DW-1:0] dat [NLINE];
  logic          done_q;
  logic [DW-1:0] rdata_q;

  // Processor-side lookup
  logic [IW-1:0] c_idx;
  logic [TW-1:0] c_tag;
  logic          c_hit;
  logic          local_go;
  assign c_idx = addr[IW-1:0];
  assign c_tag = addr[AW-1:IW];
  assign c_hit = (st[c_idx] != ST_INV) && (tg[c_idx] == c_tag);
  assign want_op  = need_op(c_hit, we, st[c_idx]);
  assign bus_req  = req && !done_q && (want_op != BOP_NONE) && !mine;
  assign local_go = req && !done_q && (want_op == BOP_NONE) && !bus_valid;

  // Bus-side lookup (snoop in address cycle, fill in response cycle)
  logic [IW-1:0] s_idx;
  logic [TW-1:0] s_tag;
  logic          s_match;
  logic          fill;
  logic [DW-1:0] fill_data;
  assign s_idx     = bus_addr[IW-1:0];
  assign s_tag     = bus_addr[AW-1:IW];
  assign s_match   = (st[s_idx] != ST_INV) && (tg[s_idx] == s_tag);
  assign snp_hit   = bus_valid && !mine && s_match;
  assign snp_dirty = snp_hit && (st[s_idx] == ST_DIRTY) && (bus_op == BOP_READ);
  assign snp_data  = dat[s_idx];
  assign fill      = mine && bus_resp;
  assign fill_data = (bus_op == BOP_READ) ? resp_data : wdata;

  // A dirty line of another address displaced by the fill
  assign vic_we   = fill && (bus_op != BOP_INVAL) && (st[s_idx] == ST_DIRTY);
  assign vic_addr = {tg[s_idx], s_idx};
  assign vic_data = dat[s_idx];

  // State probe
  logic [IW-1:0] p_idx;
  assign p_idx    = probe_addr[IW-1:0];
  assign probe_st = (st[p_idx] != ST_INV && tg[p_idx] == probe_addr[AW-1:IW]) ? st[p_idx] : ST_INV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINE; i++) begin
        st[i]  <= ST_INV;
        tg[i]  <= '0;
        dat[i] <= '0;
      end
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (local_go) begin
        done_q <= 1'b1;
        if (we) begin
          st[c_idx]  <= ST_DIRTY;
          dat[c_idx] <= wdata;
          rdata_q    <= wdata;
        end else begin
          rdata_q <= dat[c_idx];
        end
      end
      if (snp_hit) st[s_idx] <= snoop_next(st[s_idx], bus_op);
      if (fill) begin
        st[s_idx]  <= fill_state(bus_op, shared_in);
        tg[s_idx]  <= s_tag;
        dat[s_idx] <= fill_data;
        rdata_q    <= fill_data;
        done_q     <= 1'b1;
      end
    end
  end

  assign done  = done_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/snoop_coh_cluster.sv
module snoop_coh_cluster #(
  parameter int NCPU  = 3,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int NLINE = 4,
  localparam int SW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCPU-1:0]    cpu_req,
  input  logic [NCPU-1:0]    cpu_we,
  input  logic [NCPU*AW-1:0] cpu_addr,
  input  logic [NCPU*DW-1:0] cpu_wdata,
  output logic [NCPU-1:0]    cpu_done,
  output logic [NCPU*DW-1:0] cpu_rdata,
  output logic               bus_valid,
  output logic [1:0]         bus_op,
  output logic [SW-1:0]      bus_src,
  output logic [AW-1:0]      bus_addr,
  output logic               bus_shared,
  output logic               bus_c2c,
  input  logic [SW-1:0]      probe_cpu,
  input  logic [AW-1:0]      probe_addr,
  output logic [1:0]         probe_state
);
  import coh_pkg::*;

  logic [NCPU-1:0]    bus_req, own_vec, snp_hit, snp_dirty, vic_we;
  logic [2*NCPU-1:0]  op_flat, probe_flat;
  logic [NCPU*DW-1:0] snp_data_flat, vic_data_flat;
  logic [NCPU*AW-1:0] vic_addr_flat;
  logic               bus_resp, bus_busy;
  logic [SW-1:0]      own_idx;
  bus_op_t            cur_op;
  logic [AW-1:0]      cur_addr;

  // Response-cycle registers, loaded in the address cycle
  logic          shared_q, c2c_q, wb_q;
  logic [DW-1:0] sup_q;
  logic [DW-1:0] sup_data, mem_rdata, resp_data;
  logic          vic_any;
  logic [AW-1:0] vic_addr;
  logic [DW-1:0] vic_data;

  coh_bus_arb #(.NCPU(NCPU), .AW(AW), .SW(SW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .op_flat(op_flat), .addr_flat(cpu_addr),
    .bus_valid(bus_valid), .bus_resp(bus_resp), .bus_busy(bus_busy),
    .own_idx(own_idx), .bus_op(cur_op), .bus_addr(cur_addr)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cache
    bus_op_t want;
    assign own_vec[g]        = bus_busy && (own_idx == SW'(g));
    assign op_flat[2*g +: 2] = want;
    coh_line_ctrl #(.AW(AW), .DW(DW), .NLINE(NLINE)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req(cpu_req[g]), .we(cpu_we[g]),
      .addr(cpu_addr[g*AW +: AW]), .wdata(cpu_wdata[g*DW +: DW]),
      .done(cpu_done[g]), .rdata(cpu_rdata[g*DW +: DW]),
      .bus_req(bus_req[g]), .want_op(want), .mine(own_vec[g]),
      .bus_valid(bus_valid), .bus_resp(bus_resp), .bus_op(cur_op), .bus_addr(cur_addr),
      .shared_in(shared_q), .resp_data(resp_data),
      .snp_hit(snp_hit[g]), .snp_dirty(snp_dirty[g]), .snp_data(snp_data_flat[g*DW +: DW]),
      .vic_we(vic_we[g]), .vic_addr(vic_addr_flat[g*AW +: AW]), .vic_data(vic_data_flat[g*DW +: DW]),
      .probe_addr(probe_addr), .probe_st(probe_flat[2*g +: 2])
    );
  end

  // Wired-OR of snoop data and of the single requester's victim
  always_comb begin
    sup_data = '0;
    vic_any  = 1'b0;
    vic_addr = '0;
    vic_data = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (snp_hit[i]) sup_data = sup_data | snp_data_flat[i*DW +: DW];
      if (vic_we[i]) begin
        vic_any  = 1'b1;
        vic_addr = vic_addr | vic_addr_flat[i*AW +: AW];
        vic_data = vic_data | vic_data_flat[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shared_q <= 1'b0;
      c2c_q    <= 1'b0;
      wb_q     <= 1'b0;
      sup_q    <= '0;
    end else if (bus_valid) begin
      shared_q <= |snp_hit;
      c2c_q    <= (|snp_hit) && (cur_op == BOP_READ);
      wb_q     <= |snp_dirty;
      sup_q    <= sup_data;
    end
  end

  // Memory answers only once the shared status is known
  assign resp_data = c2c_q ? sup_q : mem_rdata;

  coh_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .raddr(cur_addr), .rdata(mem_rdata),
    .wa_en(bus_resp && wb_q), .wa_addr(cur_addr), .wa_data(sup_q),
    .wb_en(vic_any), .wb_addr(vic_addr), .wb_data(vic_data)
  );

  assign bus_op      = cur_op;
  assign bus_src     = own_idx;
  assign bus_addr    = cur_addr;
  assign bus_shared  = bus_resp && shared_q;
  assign bus_c2c     = bus_resp && c2c_q;
  assign probe_state = (int'(probe_cpu) < NCPU) ? probe_flat[int'(probe_cpu)*2 +: 2] : 2'd0;
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int NCPU = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_resp,
  input logic            bus_shared,
  input logic            bus_c2c,
  input logic [NCPU-1:0] own_vec,
  input logic [NCPU-1:0] snp_hit,
  input logic [NCPU-1:0] snp_dirty
);
  a_r9_resp_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> (bus_resp && !bus_valid));

  a_r9_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || bus_resp) |-> $onehot(own_vec));

  a_r3_shared_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_shared |-> $past(bus_valid));

  a_r3_c2c_needs_shared: assert property (@(posedge clk) disable iff (!rst_n)
    bus_c2c |-> bus_shared);

  a_r8_one_dirty_supplier: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snp_dirty));

  a_r7_dirty_copy_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (|snp_dirty) |-> ($countones(snp_hit) == 1));

  a_r7_no_self_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit & own_vec) == '0);
endmodule

bind snoop_coh_cluster coh_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_resp(bus_resp),
  .bus_shared(bus_shared), .bus_c2c(bus_c2c), .own_vec(own_vec),
  .snp_hit(snp_hit), .snp_dirty(snp_dirty)
);

// File: tb/sim_snoop_coh_cluster.sv
module sim_snoop_coh_cluster;
  localparam int NCPU = 3, AW = 4, DW = 8, NLINE = 4, SW = 2;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCPU-1:0] cpu_req = '0, cpu_we = '0, cpu_done;
  logic [NCPU*AW-1:0] cpu_addr = '0;
  logic [NCPU*DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic bus_valid, bus_shared, bus_c2c;
  logic [1:0] bus_op, probe_state;
  logic [SW-1:0] bus_src, probe_cpu = '0;
  logic [AW-1:0] bus_addr, probe_addr = '0;

  always #(TCLK/2) clk = ~clk;

  snoop_coh_cluster #(.NCPU(NCPU), .AW(AW), .DW(DW), .NLINE(NLINE)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_src(bus_src), .bus_addr(bus_addr),
    .bus_shared(bus_shared), .bus_c2c(bus_c2c),
    .probe_cpu(probe_cpu), .probe_addr(probe_addr), .probe_state(probe_state)
  );

  int checks = 0, fails = 0;
  int txn_cnt = 0;
  logic [1:0] last_op = 2'd0;
  logic last_sh = 1'b0, last_c2c = 1'b0, seen_a = 1'b0;

  // Bus monitor: counts address cycles, captures response-cycle flags
  always @(negedge clk) begin
    if (seen_a) begin
      last_sh  <= bus_shared;
      last_c2c <= bus_c2c;
    end
    seen_a <= bus_valid;
    if (bus_valid) begin
      txn_cnt <= txn_cnt + 1;
      last_op <= bus_op;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input int c, input logic [AW-1:0] a, output logic [1:0] st);
    probe_cpu  = SW'(c);
    probe_addr = a;
    #1;
    st = probe_state;
  endtask

  task automatic run_op(input int c, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output int ntx);
    int base, n;
    @(negedge clk);
    base = txn_cnt;
    cpu_we[c] = w;
    cpu_addr[c*AW +: AW] = a;
    cpu_wdata[c*DW +: DW] = d;
    cpu_req[c] = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_done[c] && n < 100);
    rd = cpu_rdata[c*DW +: DW];
    cpu_req[c] = 1'b0;
    if (n >= 100) check("R9 request completes", 0, 1);
    ntx = txn_cnt - base;
  endtask

  function automatic logic [DW-1:0] seed(input int a);
    return DW'((a << 4) + a + 3);
  endfunction

  typedef struct packed {
    logic [1:0]    cpu;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [DW-1:0] rd;
    logic [1:0]    op;    // 0 none 1 read 2 write-miss 3 invalidate
    logic [1:0]    st;    // 0 I 1 E 2 S 3 D
    logic          sh;
    logic [1:0]    ccpu;
    logic [AW-1:0] caddr;
    logic [1:0]    cst;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 4'd1, 8'h00, 8'h14, 2'd1, 2'd1, 1'b0, 2'd1, 4'd1, 2'd0}, // R2
    '{2'd0, 1'b1, 4'd1, 8'hAA, 8'hAA, 2'd0, 2'd3, 1'b0, 2'd1, 4'd1, 2'd0}, // R4
    '{2'd1, 1'b0, 4'd1, 8'h00, 8'hAA, 2'd1, 2'd2, 1'b1, 2'd0, 4'd1, 2'd2}, // R3 R7 R8
    '{2'd2, 1'b0, 4'd1, 8'h00, 8'hAA, 2'd1, 2'd2, 1'b1, 2'd1, 4'd1, 2'd2}, // R3
    '{2'd1, 1'b1, 4'd1, 8'hBB, 8'hBB, 2'd3, 2'd3, 1'b0, 2'd0, 4'd1, 2'd0}, // R5
    '{2'd0, 1'b1, 4'd1, 8'hCC, 8'hCC, 2'd2, 2'd3, 1'b0, 2'd1, 4'd1, 2'd0}, // R6
    '{2'd2, 1'b0, 4'd1, 8'h00, 8'hCC, 2'd1, 2'd2, 1'b1, 2'd0, 4'd1, 2'd2}, // R3 R7
    '{2'd1, 1'b0, 4'd5, 8'h00, 8'h58, 2'd1, 2'd1, 1'b0, 2'd0, 4'd5, 2'd0}, // R2
    '{2'd1, 1'b0, 4'd5, 8'h00, 8'h58, 2'd0, 2'd1, 1'b0, 2'd1, 4'd1, 2'd0}, // R4
    '{2'd0, 1'b1, 4'd9, 8'hDD, 8'hDD, 2'd2, 2'd3, 1'b0, 2'd2, 4'd1, 2'd2}, // R6 R7
    '{2'd2, 1'b0, 4'd9, 8'h00, 8'hDD, 2'd1, 2'd2, 1'b1, 2'd0, 4'd9, 2'd2}, // R3
    '{2'd0, 1'b0, 4'd1, 8'h00, 8'hCC, 2'd1, 2'd1, 1'b0, 2'd2, 4'd9, 2'd2}, // R8 supplier write-back
    '{2'd1, 1'b1, 4'd2, 8'hEE, 8'hEE, 2'd2, 2'd3, 1'b0, 2'd0, 4'd2, 2'd0}, // R6
    '{2'd1, 1'b0, 4'd6, 8'h00, 8'h69, 2'd1, 2'd1, 1'b0, 2'd1, 4'd2, 2'd0}, // R8 dirty victim
    '{2'd0, 1'b0, 4'd2, 8'h00, 8'hEE, 2'd1, 2'd1, 1'b0, 2'd1, 4'd6, 2'd1}, // R8 R2
    '{2'd2, 1'b0, 4'd2, 8'h00, 8'hEE, 2'd1, 2'd2, 1'b1, 2'd0, 4'd2, 2'd2}, // R3 R7
    '{2'd2, 1'b0, 4'd2, 8'h00, 8'hEE, 2'd0, 2'd2, 1'b0, 2'd0, 4'd2, 2'd2}, // R4
    '{2'd0, 1'b1, 4'd2, 8'h77, 8'h77, 2'd3, 2'd3, 1'b0, 2'd2, 4'd2, 2'd0}  // R5
  };

  function automatic string tag_of(input vec_t v);
    case (v.op)
      2'd0: return "R4";
      2'd1: return v.sh ? "R3" : "R2";
      2'd2: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] st, st0, st1;
    logic [DW-1:0] rd;
    int ntx, base;
    logic got0, got1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCPU; c++) begin
      probe(c, 4'(c + 1), st);
      check("R1 line invalid after reset", st, 0);
    end
    check("R1 no bus activity", bus_valid, 0);
    check("R1 no done", cpu_done, 0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VEC[i];
      t = tag_of(v);
      run_op(v.cpu, v.we, v.addr, v.wd, rd, ntx);
      check({t, " bus transactions"}, ntx, (v.op == 2'd0) ? 0 : 1);
      if (v.op != 2'd0 && ntx == 1) check({t, " bus op code"}, last_op, v.op);
      if (!v.we) check({t, " read data"}, rd, v.rd);
      if (v.op == 2'd1) begin
        check({t, " shared response"}, last_sh, v.sh);
        check({t, " cache supplied data"}, last_c2c, v.sh);
      end
      probe(v.cpu, v.addr, st);
      check({t, " requester state"}, st, v.st);
      probe(v.ccpu, v.caddr, st);
      check("R7 other copy state", st, v.cst);
    end

    // R8: memory holds the seed where nothing was written
    run_op(2, 1'b0, 4'd10, 8'h00, rd, ntx);
    check("R2 untouched word from memory", rd, seed(10));

    // R9: two write-misses raised together are served one after the other
    @(negedge clk);
    base = txn_cnt;
    cpu_we[0] = 1'b1; cpu_addr[0 +: AW] = 4'd3; cpu_wdata[0 +: DW] = 8'h11;
    cpu_we[1] = 1'b1; cpu_addr[AW +: AW] = 4'd3; cpu_wdata[DW +: DW] = 8'h22;
    cpu_req[1:0] = 2'b11;
    got0 = 1'b0; got1 = 1'b0;
    for (int n = 0; n < 60 && !(got0 && got1); n++) begin
      @(negedge clk);
      if (cpu_done[0]) begin got0 = 1'b1; cpu_req[0] = 1'b0; end
      if (cpu_done[1]) begin got1 = 1'b1; cpu_req[1] = 1'b0; end
    end
    check("R9 both requests complete", got0 && got1, 1);
    check("R9 two transactions", txn_cnt - base, 2);
    probe(0, 4'd3, st0);
    probe(1, 4'd3, st1);
    check("R6 exactly one dirty winner", (st0 == 2'd3) ^ (st1 == 2'd3), 1);
    check("R6 loser invalid", (st0 == 2'd0) || (st1 == 2'd0), 1);
    run_op(2, 1'b0, 4'd3, 8'h00, rd, ntx);
    check("R3 winner data supplied", rd, (st0 == 2'd3) ? 8'h11 : 8'h22);
    check("R3 cache supplied flag", last_c2c, 1);

    // R1: reset again clears every line
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    probe(0, 4'd2, st);
    check("R1 line invalid after second reset", st, 0);
    probe(2, 4'd3, st);
    check("R1 line invalid after second reset", st, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule